// File: doc/BRIEF.md
# PHY Bring-Up Sequencer

This block brings a storage-card PHY out of reset with no software involved. After reset is released it walks a fixed chain of register accesses over a simple request/acknowledge port into the PHY's 8-bit register space. First it enables the I/O pads. Then it waits for pad calibration to report completion. Only after that does it switch on receivers, pull-ups and drivers for the command, data, strobe and clock lines, and finally it selects the default low-speed operating mode.

Nearly every step is a read-modify-write: the sequencer reads a register, ORs in a fixed set of enable bits, and writes the result back, so bits it does not own are kept. The calibration wait is a read loop guarded by a cycle-count timeout. Each single access has its own acknowledge timeout. Any failed or unanswered access, or an expired calibration wait, stops the chain at once and raises a sticky error. A clean finish gives a one-cycle done pulse. A start pulse given while the block is idle runs the whole chain again.

Top module: `phy_bringup_seq`

## Requirements
- R1: While reset is high, phy_req, done and err are low. The chain begins on its own, with a read of register 0x01, as soon as reset is released.
- R2: The pad steps come first, in this order: register 0x01 is read and written back with bits 6 and 1 set (OR 0x42), then register 0x02 is read and written back with bit 1 set (OR 0x02). All other bits of each register are preserved.
- R3: After the pad steps, register 0x03 is read repeatedly until a read returns bit 4 set. Register 0x03 is never written, and no line register is accessed before bit 4 is seen.
- R4: If calibration has not been seen once POLL_LIMIT cycles have passed since the read loop began, the read that completes next sets err and no further access is made. The cycle count starts again from zero each time the loop is entered.
- R5: After calibration the following registers are updated by read-modify-write, in this order: 0x06 OR 0x03, 0x08 OR 0x02, 0x20 OR 0x01, 0x07 OR 0xFF, 0x09 OR 0xFF, 0x21 OR 0xFF, 0x22 OR 0x01, 0x23 OR 0x01, 0x0F OR 0x07. Bits outside each mask are preserved.
- R6: The last access writes 0x04 to register 0x11, and register 0x11 is never read.
- R7: An access acknowledged with phy_err high ends the chain: err is set and no further request is issued.
- R8: If a request gets no acknowledge within ACC_LIMIT cycles, it is withdrawn (phy_req goes low), err is set and no further request is issued.
- R9: phy_req stays high, with phy_wr, phy_addr and phy_wdata unchanged, until phy_ack arrives or the access times out. Only one access is outstanding at a time, and the chain completes the same way for any acknowledge latency.
- R10: done is a single-cycle pulse, given only after the final write is acknowledged and never while err is high. err stays high until a start is accepted.
- R11: A start pulse while idle clears err and runs the chain again from its first step. A start pulse while the chain is running has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Re-run request, accepted only while idle |
| phy_req | output | 1 | Access request, held until acknowledged or timed out |
| phy_wr | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 8 | PHY register address |
| phy_wdata | output | 8 | Write data |
| phy_ack | input | 1 | One-cycle access acknowledge |
| phy_err | input | 1 | Access failed, valid with phy_ack |
| phy_rdata | input | 8 | Read data, valid with phy_ack |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Sticky failure flag |

## Verification
The assertions check on every cycle that the request fields hold steady while an access is pending, that register 0x03 is never written, and that any write to 0x11 carries exactly 0x04. They also check that done lasts one cycle and never appears together with err, that err holds until a start arrives, and that the calibration timer clears whenever the read loop is left. Other behaviour can only be shown by the bench scenarios, which run a register model against the block: the exact order of accesses and the values they read and write, preservation of unrelated bits, where the chain stops after an error, a timeout or a hung access, and whether start is accepted or ignored.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 8;

    typedef enum logic [1:0] {
        K_RMW   = 2'd0,
        K_POLL  = 2'd1,
        K_WRITE = 2'd2
    } step_kind_e;

    typedef struct packed {
        step_kind_e          kind;
        logic [REG_AW-1:0]   addr;
        logic [REG_DW-1:0]   mask;
    } step_t;

    typedef struct packed {
        logic                wr;
        logic [REG_AW-1:0]   addr;
        logic [REG_DW-1:0]   data;
    } xact_t;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_RD_GO   = 3'd1,
        S_RD_WAIT = 3'd2,
        S_WR_GO   = 3'd3,
        S_WR_WAIT = 3'd4
    } seq_state_e;

    localparam int NUM_STEPS = 13;
    localparam int IDX_W     = $clog2(NUM_STEPS);

    localparam logic [REG_AW-1:0] CAL_REG  = 8'h03;
    localparam logic [REG_AW-1:0] MODE_REG = 8'h11;
    localparam logic [REG_DW-1:0] MODE_VAL = 8'h04;

    // Fixed bring-up chain; the order is the behaviour.
    function automatic step_t step_at(input logic [IDX_W-1:0] idx);
        step_t s;
        case (idx)
            4'd0:    s = '{K_RMW,   8'h01, 8'h42};
            4'd1:    s = '{K_RMW,   8'h02, 8'h02};
            4'd2:    s = '{K_POLL,  CAL_REG, 8'h10};
            4'd3:    s = '{K_RMW,   8'h06, 8'h03};
            4'd4:    s = '{K_RMW,   8'h08, 8'h02};
            4'd5:    s = '{K_RMW,   8'h20, 8'h01};
            4'd6:    s = '{K_RMW,   8'h07, 8'hFF};
            4'd7:    s = '{K_RMW,   8'h09, 8'hFF};
            4'd8:    s = '{K_RMW,   8'h21, 8'hFF};
            4'd9:    s = '{K_RMW,   8'h22, 8'h01};
            4'd10:   s = '{K_RMW,   8'h23, 8'h01};
            4'd11:   s = '{K_RMW,   8'h0F, 8'h07};
            default: s = '{K_WRITE, MODE_REG, MODE_VAL};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/phy_poll_timer.sv
module phy_poll_timer #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == CW'(LIMIT));

    // R4
    timer_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> !expired);

endmodule

// File: rtl/phy_xact_engine.sv
module phy_xact_engine
    import phy_bringup_pkg::*;
#(
    parameter int ACC_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  xact_t             cmd,
    output logic              phy_req,
    output logic              phy_wr,
    output logic [REG_AW-1:0] phy_addr,
    output logic [REG_DW-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic              phy_err,
    input  logic [REG_DW-1:0] phy_rdata,
    output logic              xdone,
    output logic              xfail,
    output logic [REG_DW-1:0] xrdata
);
    localparam int CW = $clog2(ACC_LIMIT + 1);

    logic              req_q;
    xact_t             cmd_q;
    logic [CW-1:0]     wait_q;
    logic              done_q;
    logic              fail_q;
    logic [REG_DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            cmd_q   <= '0;
            wait_q  <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            if (!req_q) begin
                if (go) begin
                    req_q  <= 1'b1;
                    cmd_q  <= cmd;
                    wait_q <= '0;
                end
            end else if (phy_ack) begin
                req_q   <= 1'b0;
                done_q  <= 1'b1;
                fail_q  <= phy_err;
                rdata_q <= phy_rdata;
            end else if (wait_q == CW'(ACC_LIMIT - 1)) begin
                req_q  <= 1'b0;
                done_q <= 1'b1;
                fail_q <= 1'b1;
            end else begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end

    assign phy_req   = req_q;
    assign phy_wr    = cmd_q.wr;
    assign phy_addr  = cmd_q.addr;
    assign phy_wdata = cmd_q.data;
    assign xdone     = done_q;
    assign xfail     = fail_q;
    assign xrdata    = rdata_q;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        phy_req && !phy_ack |=> $stable(phy_addr) && $stable(phy_wr) && $stable(phy_wdata));

    // R3
    no_cal_write_chk: assert property (@(posedge clk) disable iff (rst)
        phy_req && phy_wr |-> phy_addr != CAL_REG);

    // R6
    mode_value_chk: assert property (@(posedge clk) disable iff (rst)
        phy_req && phy_addr == MODE_REG |-> phy_wr && phy_wdata == MODE_VAL);

endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
    import phy_bringup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              xdone,
    input  logic              xfail,
    input  logic [REG_DW-1:0] xrdata,
    input  logic              poll_expired,
    output logic              go,
    output xact_t             cmd,
    output logic              poll_active,
    output logic              done,
    output logic              err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS - 1);

    seq_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [REG_DW-1:0] wval_q;
    logic              done_q;
    logic              err_q;

    step_t step;
    logic  in_wait;
    logic  hit;
    logic  advance;
    logic  abort;

    always_comb begin
        step        = step_at(idx_q);
        in_wait     = (state_q == S_RD_WAIT) || (state_q == S_WR_WAIT);
        hit         = (xrdata & step.mask) != '0;
        poll_active = ((state_q == S_RD_GO) || (state_q == S_RD_WAIT)) && (step.kind == K_POLL);

        advance = xdone && !xfail &&
                  ((state_q == S_WR_WAIT) ||
                   (state_q == S_RD_WAIT && step.kind == K_POLL && hit));
        abort   = xdone && in_wait &&
                  (xfail || (state_q == S_RD_WAIT && step.kind == K_POLL && !hit && poll_expired));

        go       = (state_q == S_RD_GO) || (state_q == S_WR_GO);
        cmd.addr = step.addr;
        if (state_q == S_WR_GO) begin
            cmd.wr   = 1'b1;
            cmd.data = wval_q;
        end else if (step.kind == K_WRITE) begin
            cmd.wr   = 1'b1;
            cmd.data = step.mask;
        end else begin
            cmd.wr   = 1'b0;
            cmd.data = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_RD_GO;
            idx_q   <= '0;
            wval_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                err_q   <= 1'b1;
                state_q <= S_IDLE;
            end else if (advance) begin
                if (idx_q == LAST_IDX) begin
                    done_q  <= 1'b1;
                    state_q <= S_IDLE;
                end else begin
                    idx_q   <= idx_q + 1'b1;
                    state_q <= S_RD_GO;
                end
            end else begin
                case (state_q)
                    S_IDLE: begin
                        if (start) begin
                            err_q   <= 1'b0;
                            idx_q   <= '0;
                            state_q <= S_RD_GO;
                        end
                    end
                    S_RD_GO: begin
                        state_q <= (step.kind == K_WRITE) ? S_WR_WAIT : S_RD_WAIT;
                    end
                    S_RD_WAIT: begin
                        if (xdone) begin
                            if (step.kind == K_POLL) begin
                                state_q <= S_RD_GO;
                            end else begin
                                wval_q  <= xrdata | step.mask;
                                state_q <= S_WR_GO;
                            end
                        end
                    end
                    S_WR_GO: begin
                        state_q <= S_WR_WAIT;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign done = done_q;
    assign err  = err_q;

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_clean_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !err);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err && !start |=> err);

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> !xdone);

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import phy_bringup_pkg::*;
#(
    parameter int POLL_LIMIT = 2000,
    parameter int ACC_LIMIT  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              phy_req,
    output logic              phy_wr,
    output logic [REG_AW-1:0] phy_addr,
    output logic [REG_DW-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic              phy_err,
    input  logic [REG_DW-1:0] phy_rdata,
    output logic              done,
    output logic              err
);
    logic              go;
    xact_t             cmd;
    logic              xdone;
    logic              xfail;
    logic [REG_DW-1:0] xrdata;
    logic              poll_active;
    logic              poll_expired;

    phy_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .xdone        (xdone),
        .xfail        (xfail),
        .xrdata       (xrdata),
        .poll_expired (poll_expired),
        .go           (go),
        .cmd          (cmd),
        .poll_active  (poll_active),
        .done         (done),
        .err          (err)
    );

    phy_xact_engine #(.ACC_LIMIT(ACC_LIMIT)) u_xact (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .cmd       (cmd),
        .phy_req   (phy_req),
        .phy_wr    (phy_wr),
        .phy_addr  (phy_addr),
        .phy_wdata (phy_wdata),
        .phy_ack   (phy_ack),
        .phy_err   (phy_err),
        .phy_rdata (phy_rdata),
        .xdone     (xdone),
        .xfail     (xfail),
        .xrdata    (xrdata)
    );

    phy_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .active  (poll_active),
        .expired (poll_expired)
    );

endmodule

// File: tb/phy_bringup_seq_bench.sv
`timescale 1ns/1ps
module phy_bringup_seq_bench;

    localparam int POLL_LIM = 60;
    localparam int ACC_LIM  = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       phy_req, phy_wr;
    logic [7:0] phy_addr, phy_wdata;
    logic       phy_ack = 1'b0;
    logic       phy_err = 1'b0;
    logic [7:0] phy_rdata = 8'h00;
    logic       done, err;

    always #2.5 clk = ~clk;

    phy_bringup_seq #(.POLL_LIMIT(POLL_LIM), .ACC_LIMIT(ACC_LIM)) u_phy_bringup_seq (
        .clk(clk), .rst(rst), .start(start),
        .phy_req(phy_req), .phy_wr(phy_wr), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_err(phy_err), .phy_rdata(phy_rdata),
        .done(done), .err(err)
    );

    // register model
    logic [7:0]  mem      [256];
    logic [7:0]  init_mem [256];
    logic [16:0] log_e    [64];
    int          log_n = 0;
    int          lat = 0;
    int          lcnt = 0;
    int          cal_after = 0;
    int          r3cnt = 0;
    bit          fail_en = 0;
    bit          fail_wr = 0;
    logic [7:0]  fail_addr = 8'h00;
    bit          hang_en = 0;
    logic [7:0]  hang_addr = 8'h00;
    int          done_cnt = 0;
    logic [7:0]  rv;

    always @(posedge clk) begin
        phy_ack <= 1'b0;
        phy_err <= 1'b0;
        if (done) done_cnt <= done_cnt + 1;
        if (rst) begin
            lcnt <= 0;
        end else if (phy_req && !phy_ack && !(hang_en && phy_addr == hang_addr)) begin
            if (lcnt < lat) begin
                lcnt <= lcnt + 1;
            end else begin
                lcnt <= 0;
                phy_ack <= 1'b1;
                rv = mem[phy_addr];
                if (phy_addr == 8'h03) rv = rv | ((r3cnt >= cal_after) ? 8'h10 : 8'h00);
                if (fail_en && phy_addr == fail_addr && phy_wr == fail_wr) begin
                    phy_err <= 1'b1;
                end else if (phy_wr) begin
                    mem[phy_addr] <= phy_wdata;
                end else begin
                    phy_rdata <= rv;
                    if (phy_addr == 8'h03) r3cnt <= r3cnt + 1;
                end
                if (log_n < 64) begin
                    log_e[log_n] <= {phy_wr, phy_addr, phy_wr ? phy_wdata : rv};
                    log_n <= log_n + 1;
                end
            end
        end
    end

    // bench view of the chain: kind 0 = read-modify-write, 1 = calibration poll, 2 = plain write
    int          b_kind [13];
    logic [7:0]  b_addr [13];
    logic [7:0]  b_mask [13];
    logic [16:0] exp_e  [64];
    int          exp_n;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic set_step(input int i, input int k, input logic [7:0] a, input logic [7:0] m);
        b_kind[i] = k; b_addr[i] = a; b_mask[i] = m;
    endtask

    task automatic build_exp(input int k);
        logic [7:0] sh [256];
        for (int i = 0; i < 256; i++) sh[i] = init_mem[i];
        exp_n = 0;
        for (int s = 0; s < 13; s++) begin
            if (b_kind[s] == 0) begin
                exp_e[exp_n] = {1'b0, b_addr[s], sh[b_addr[s]]}; exp_n++;
                sh[b_addr[s]] = sh[b_addr[s]] | b_mask[s];
                exp_e[exp_n] = {1'b1, b_addr[s], sh[b_addr[s]]}; exp_n++;
            end else if (b_kind[s] == 1) begin
                for (int j = 0; j <= k; j++) begin
                    exp_e[exp_n] = {1'b0, 8'h03, sh[3] | ((j >= k) ? 8'h10 : 8'h00)}; exp_n++;
                end
            end else begin
                exp_e[exp_n] = {1'b1, b_addr[s], b_mask[s]}; exp_n++;
            end
        end
    endtask

    task automatic check_log(input string req);
        chk(log_n == exp_n, req, "access count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            chk(log_e[i] == exp_e[i], req, $sformatf("access %0d", i), int'(log_e[i]), int'(exp_e[i]));
    endtask

    task automatic snapshot();
        for (int i = 0; i < 256; i++) init_mem[i] = mem[i];
        log_n = 0; r3cnt = 0;
    endtask

    task automatic apply_reset();
        rst = 1'b1; start = 1'b0;
        repeat (3) @(negedge clk);
        // R1 outputs quiet in reset
        chk(phy_req == 1'b0, "R1", "phy_req in reset", phy_req, 0);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(err == 1'b0, "R1", "err in reset", err, 0);
        for (int i = 0; i < 256; i++) mem[i] = init_mem[i];
        log_n = 0; r3cnt = 0; done_cnt = 0;
        rst = 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) init_mem[i] = 8'h00;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end(output bit saw_done);
        saw_done = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (done) begin saw_done = 1; return; end
            if (err) return;
        end
    endtask

    task automatic t_reset_and_basic();
        bit sd;
        clear_mem(); cal_after = 2; lat = 0;
        build_exp(2);
        apply_reset();
        wait_end(sd);
        chk(sd, "R10", "done after clean run", sd, 1);
        chk(err == 1'b0, "R10", "err after clean run", err, 0);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width one cycle", done, 0);
        // R1 R2 R3 R5 R6 order and values
        check_log("R5");
        chk(mem[8'h0F] == 8'h07, "R5", "reg 0x0F", mem[8'h0F], 8'h07);
        chk(mem[8'h11] == 8'h04, "R6", "reg 0x11", mem[8'h11], 8'h04);
        chk(log_e[0] == {1'b0, 8'h01, 8'h00}, "R1", "first access", int'(log_e[0]), 'h100);
    endtask

    task automatic t_preserve_bits();
        bit sd;
        clear_mem();
        init_mem[8'h01] = 8'h81; init_mem[8'h02] = 8'h10; init_mem[8'h06] = 8'h40;
        init_mem[8'h20] = 8'h80; init_mem[8'h0F] = 8'h30; init_mem[8'h11] = 8'hAA;
        cal_after = 0; lat = 0;
        build_exp(0);
        apply_reset();
        wait_end(sd);
        chk(sd, "R2", "done with preset bits", sd, 1);
        check_log("R2");
        chk(mem[8'h01] == 8'hC3, "R2", "reg 0x01 kept bits", mem[8'h01], 8'hC3);
        chk(mem[8'h02] == 8'h12, "R2", "reg 0x02 kept bits", mem[8'h02], 8'h12);
        chk(mem[8'h06] == 8'h43, "R5", "reg 0x06 kept bits", mem[8'h06], 8'h43);
        chk(mem[8'h0F] == 8'h37, "R5", "reg 0x0F kept bits", mem[8'h0F], 8'h37);
        chk(mem[8'h11] == 8'h04, "R6", "reg 0x11 replaced", mem[8'h11], 8'h04);
    endtask

    task automatic t_poll_timeout();
        bit sd;
        bit seen06;
        int n0;
        clear_mem(); cal_after = 100000; lat = 0;
        apply_reset();
        wait_end(sd);
        chk(!sd && err, "R4", "err on calibration timeout", err, 1);
        seen06 = 0;
        for (int i = 0; i < log_n; i++) if (log_e[i][15:8] == 8'h06) seen06 = 1;
        chk(!seen06, "R3", "line reg touched before calibration", seen06, 0);
        chk(log_e[log_n-1][15:8] == 8'h03, "R4", "last access addr", log_e[log_n-1][15:8], 3);
        n0 = log_n;
        repeat (20) @(negedge clk);
        chk(log_n == n0, "R4", "no access after timeout", log_n, n0);
        chk(err == 1'b1, "R10", "err sticky while idle", err, 1);
        chk(done_cnt == 0, "R10", "no done after timeout", done_cnt, 0);
    endtask

    task automatic t_rerun_after_error();
        bit sd;
        cal_after = 1;
        snapshot();
        build_exp(1);
        pulse_start();
        chk(err == 1'b0, "R11", "err cleared by start", err, 1'b0);
        wait_end(sd);
        chk(sd, "R11", "rerun completes", sd, 1);
        check_log("R11");
    endtask

    task automatic t_start_ignored();
        bit sd;
        cal_after = 1;
        repeat (3) @(negedge clk);
        snapshot(); done_cnt = 0;
        build_exp(1);
        pulse_start();
        repeat (6) @(negedge clk);
        pulse_start();
        wait_end(sd);
        repeat (10) @(negedge clk);
        chk(done_cnt == 1, "R11", "single done despite busy start", done_cnt, 1);
        check_log("R11");
    endtask

    task automatic t_access_error();
        bit sd;
        int n0;
        clear_mem(); cal_after = 0; lat = 0;
        fail_en = 1; fail_addr = 8'h08; fail_wr = 1;
        apply_reset();
        wait_end(sd);
        chk(!sd && err, "R7", "err on failed access", err, 1);
        chk(log_n == 9, "R7", "accesses before stop", log_n, 9);
        chk(log_e[8][16:8] == {1'b1, 8'h08}, "R7", "failing access", log_e[8][16:8], 'h108);
        n0 = log_n;
        repeat (20) @(negedge clk);
        chk(log_n == n0 && !phy_req, "R7", "no access after failure", log_n, n0);
        fail_en = 0;
    endtask

    task automatic t_access_hang();
        bit sd;
        clear_mem(); cal_after = 0; lat = 0;
        hang_en = 1; hang_addr = 8'h21;
        apply_reset();
        wait_end(sd);
        chk(!sd && err, "R8", "err on unanswered access", err, 1);
        chk(phy_req == 1'b0, "R8", "request withdrawn", phy_req, 0);
        chk(log_n == 15, "R8", "accesses before hang", log_n, 15);
        repeat (20) @(negedge clk);
        chk(phy_req == 1'b0 && log_n == 15, "R8", "no retry after hang", log_n, 15);
        hang_en = 0;
    endtask

    task automatic t_slow_responder();
        bit sd;
        clear_mem(); init_mem[8'h09] = 8'h5A; cal_after = 3; lat = 4;
        build_exp(3);
        apply_reset();
        wait_end(sd);
        chk(sd, "R9", "done with slow responder", sd, 1);
        check_log("R9");
        lat = 0;
    endtask

    initial begin
        set_step(0, 0, 8'h01, 8'h42);  set_step(1, 0, 8'h02, 8'h02);
        set_step(2, 1, 8'h03, 8'h10);  set_step(3, 0, 8'h06, 8'h03);
        set_step(4, 0, 8'h08, 8'h02);  set_step(5, 0, 8'h20, 8'h01);
        set_step(6, 0, 8'h07, 8'hFF);  set_step(7, 0, 8'h09, 8'hFF);
        set_step(8, 0, 8'h21, 8'hFF);  set_step(9, 0, 8'h22, 8'h01);
        set_step(10, 0, 8'h23, 8'h01); set_step(11, 0, 8'h0F, 8'h07);
        set_step(12, 2, 8'h11, 8'h04);
        clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;

        t_reset_and_basic();
        t_preserve_bits();
        t_poll_timeout();
        t_rerun_after_error();
        t_start_ignored();
        t_access_error();
        t_access_hang();
        t_slow_responder();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule